// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block collects single-cycle event pulses from the rest of a host controller into a sticky status word. The status word is then filtered by an enable mask to produce one level-sensitive interrupt line. A status bit is latched by its event and stays latched until software acknowledges it by writing a 1 to that bit position. A bit on which an event and an acknowledge land in the same cycle stays latched.

Software changes the enable mask through two write addresses. One address sets the mask bits written as 1 and the other clears them. Both addresses read back the same current mask. The top mask bit is a master enable: while it is clear the interrupt line stays low whatever the status and per-source enables are. Reads are combinational from the word address. Writes take effect at the next rising clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status word (address 0), the mask read through addresses 1 and 2, and `irq` are all zero.
- R2: A 1 on `evt_pulse[b]` for one cycle sets status bit b at that clock edge, and the bit stays set afterwards. The source bit positions are: 0 scheduling overrun, 1 done-list write-back, 2 start of frame, 3 resume detected, 4 unrecoverable error, 5 frame number overflow, 6 root port change, 30 ownership change.
- R3: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an event pulse and a clearing write to address 0 hit the same bit in the same cycle, that bit is set after the edge.
- R5: A write to address 1 sets every mask bit written as 1 and leaves every bit written as 0 unchanged. The mask uses the same bit positions as the status word, plus bit 31.
- R6: A write to address 2 clears every mask bit written as 1 and leaves every bit written as 0 unchanged.
- R7: Reads of address 1 and address 2 both return the current mask.
- R8: `irq` is 1 exactly when mask bit 31 (master) is 1 and at least one status bit is 1 whose mask bit is also 1.
- R9: Positions outside the source list (and outside bit 31 for the mask) read as 0 and ignore events and writes. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 status, 1 mask set, 2 mask clear |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_pulse | input | 32 | One-cycle event pulses, one per status bit position |
| irq | output | 1 | Level interrupt output |

## Verification
The hardest case to reach is an event pulse that lands in the same cycle as an acknowledge write to the same bit. The stimulus reaches it by driving the pulse and the write to address 0 together in one cycle, for every bit position. The per-source gating is also exercised across the full product of source and enable bit, with the master bit set and with it clear. This shows that a source raises the line only through its own enable bit.

// File: rtl/irq_pkg.sv
// Package: shared constants and register address codes for the interrupt
// status and enable controller. Assumes a 32-bit register data path.
package irq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    // Implemented source positions: bits 0..6 and bit 30.
    localparam logic [DATA_W-1:0] SRC_MASK_DEF = 32'h4000_007F;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_status_reg.sv
// Sticky status word. Each implemented bit is set by its event pulse and
// cleared by a 1 in the clear vector. The event has priority over the clear.
// Unimplemented bits are tied to zero. Assumes pulses are synchronous to clk.
module irq_status_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] SRC_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (SRC_MASK[i]) begin : g_impl
            // Purpose: latch the event, drop on acknowledge, event wins.
            always_ff @(posedge clk) begin
                if (!rst_n)      q[i] <= 1'b0;
                else if (evt[i]) q[i] <= 1'b1;
                else if (clr[i]) q[i] <= 1'b0;
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Enable mask with separate set and clear strobes. The two strobes come from
// different addresses, so they never carry ones in the same cycle. If they
// did, the clear would win. Bits outside IMPL are held at zero.
module irq_mask_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic [W-1:0] mask_r;

    // Purpose: apply the set and clear strobes to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_r <= '0;
        else        mask_r <= ((mask_r | set) & ~clr) & IMPL;
    end

    assign q = mask_r;
endmodule

// File: rtl/irq_combine.sv
// Interrupt combiner: ANDs status with mask over the source bits and gates
// the OR of the result with the master bit. Purely combinational.
module irq_combine #(
    parameter int W = 32,
    parameter logic [W-1:0] SRC_MASK = '1,
    parameter int MASTER_BIT = W-1
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] pending;

    // Purpose: find enabled pending sources and apply the master gate.
    always_comb begin
        pending = status & mask & SRC_MASK;
        irq     = mask[MASTER_BIT] & (|pending);
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// Top level: decodes the register bus into status-clear, mask-set and
// mask-clear strobes and muxes read data. The sticky status, the mask and
// the combiner are instantiated below. Reads are combinational and writes
// act at the rising edge. Assumes one access per cycle.
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter logic [DATA_W-1:0] SRC_MASK = SRC_MASK_DEF,
    parameter int MASTER_BIT = DATA_W-1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] evt_pulse,
    output logic              irq
);
    localparam logic [DATA_W-1:0] EN_MASK = SRC_MASK | (DATA_W'(1) << MASTER_BIT);

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] st_clr;
    logic [DATA_W-1:0] mk_set;
    logic [DATA_W-1:0] mk_clr;

    // Purpose: turn a bus write into the strobe of the addressed register.
    always_comb begin
        st_clr = '0;
        mk_set = '0;
        mk_clr = '0;
        if (bus_wr) begin
            unique case (reg_addr_e'(bus_addr))
                REG_STATUS: st_clr = bus_wdata;
                REG_EN_SET: mk_set = bus_wdata;
                REG_EN_CLR: mk_clr = bus_wdata;
                default:    ;
            endcase
        end
    end

    // Purpose: select read data; both mask addresses return the mask.
    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            REG_STATUS:            bus_rdata = status_q;
            REG_EN_SET, REG_EN_CLR: bus_rdata = mask_q;
            default:               bus_rdata = '0;
        endcase
    end

    irq_status_reg #(.W(DATA_W), .SRC_MASK(SRC_MASK)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr(st_clr), .q(status_q)
    );

    irq_mask_reg #(.W(DATA_W), .IMPL(EN_MASK)) u_mask (
        .clk(clk), .rst_n(rst_n), .set(mk_set), .clr(mk_clr), .q(mask_q)
    );

    irq_combine #(.W(DATA_W), .SRC_MASK(SRC_MASK), .MASTER_BIT(MASTER_BIT)) u_comb (
        .status(status_q), .mask(mask_q), .irq(irq)
    );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
// Checker for irq_status_ctrl. It watches the bus, the events, the output and
// the two internal words, and it is bound into every instance of the top.
module irq_status_ctrl_chk
    import irq_pkg::*;
#(
    parameter logic [DATA_W-1:0] SRC_MASK = SRC_MASK_DEF,
    parameter int MASTER_BIT = DATA_W-1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] evt_pulse,
    input logic              irq,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] mask_q
);
    localparam logic [DATA_W-1:0] EN_MASK = SRC_MASK | (DATA_W'(1) << MASTER_BIT);

    logic [DATA_W-1:0] ack_vec;
    assign ack_vec = (bus_wr && bus_addr == 2'd0) ? bus_wdata : '0;

    // R3: bits not acknowledged stay set
    a_r3_unacked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~ack_vec)) == $past(status_q & ~ack_vec)));

    // R2, R4: an event always leaves its bit set, even with a clear
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pulse & SRC_MASK)) |=> ((status_q & $past(evt_pulse & SRC_MASK)) == $past(evt_pulse & SRC_MASK)));

    // R5: set write raises the written mask bits
    a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> ((mask_q & $past(bus_wdata & EN_MASK)) == $past(bus_wdata & EN_MASK)));

    // R6: clear write drops the written mask bits
    a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> ((mask_q & $past(bus_wdata)) == '0));

    // R8: no interrupt without the master bit
    a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[MASTER_BIT] |-> !irq);

    // R8: an interrupt needs an enabled pending source
    a_r8_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(status_q & mask_q & SRC_MASK)));

    // R9: status reads never show unused positions
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> ((bus_rdata & ~SRC_MASK) == '0));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.SRC_MASK(SRC_MASK), .MASTER_BIT(MASTER_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .irq(irq), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/tb_irq_status_ctrl.sv
// Bench: walks every bit position through status and mask, then sweeps
// source against enable with the master on and off. Expected values are
// formed from the requirements.
module tb_irq_status_ctrl;
    localparam logic [31:0] SRC  = 32'h4000_007F;
    localparam logic [31:0] MIMP = 32'hC000_007F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_pulse = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the given write and event inputs, then idle.
    task automatic cyc(input logic wr, input logic [1:0] a, input logic [31:0] d, input logic [31:0] ev);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_pulse = ev;
        @(posedge clk); #1;
        bus_wr = 1'b0; evt_pulse = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a; #0.5; v = bus_rdata;
    endtask

    logic [31:0] v;
    logic [31:0] bitv;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 mask@1", v, 32'h0);
        rd(2'd2, v); chk("R1 mask@2", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(2'd3, v); chk("R9 addr3", v, 32'h0);

        for (int b = 0; b < 32; b++) begin
            bitv = 32'h1 << b;
            cyc(1'b0, 2'd0, '0, bitv);
            rd(2'd0, v); chk("R2 R9 event sets", v, bitv & SRC);
            cyc(1'b0, 2'd0, '0, '0);
            rd(2'd0, v); chk("R2 holds", v, bitv & SRC);
            cyc(1'b1, 2'd0, ~bitv, '0);
            rd(2'd0, v); chk("R3 zero no effect", v, bitv & SRC);
            cyc(1'b1, 2'd0, bitv, '0);
            rd(2'd0, v); chk("R3 clear", v, 32'h0);
            cyc(1'b1, 2'd0, bitv, bitv);
            rd(2'd0, v); chk("R4 event wins", v, bitv & SRC);
            cyc(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
            rd(2'd0, v); chk("R3 clear all", v, 32'h0);
        end

        for (int b = 0; b < 32; b++) begin
            bitv = 32'h1 << b;
            cyc(1'b1, 2'd1, bitv, '0);
            rd(2'd1, v); chk("R5 R9 set", v, bitv & MIMP);
            rd(2'd2, v); chk("R7 read@2", v, bitv & MIMP);
            cyc(1'b1, 2'd1, 32'h0, '0);
            rd(2'd1, v); chk("R5 zero no effect", v, bitv & MIMP);
            cyc(1'b1, 2'd2, ~bitv, '0);
            rd(2'd2, v); chk("R6 zero no effect", v, bitv & MIMP);
            cyc(1'b1, 2'd2, bitv, '0);
            rd(2'd1, v); chk("R6 clear", v, 32'h0);
            cyc(1'b1, 2'd3, 32'hFFFF_FFFF, 32'h0);
            rd(2'd3, v); chk("R9 addr3 write", v, 32'h0);
            rd(2'd0, v); chk("R9 addr3 status", v, 32'h0);
            rd(2'd1, v); chk("R9 addr3 mask", v, 32'h0);
        end

        // R8 sweep: source s pending, enable t, master m
        for (int s = 0; s < 32; s++) begin
            if (SRC[s]) begin
                for (int t = 0; t < 32; t++) begin
                    if (SRC[t]) begin
                        for (int m = 0; m < 2; m++) begin
                            cyc(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
                            cyc(1'b1, 2'd2, 32'hFFFF_FFFF, 32'h1 << s);
                            chk("R8 no mask", {31'b0, irq}, 32'h0);
                            cyc(1'b1, 2'd1, (32'h1 << t) | (m == 1 ? 32'h8000_0000 : 32'h0), '0);
                            chk("R8 irq", {31'b0, irq}, {31'b0, (m == 1) && (s == t)});
                            if (m == 1 && s == t) begin
                                cyc(1'b1, 2'd0, 32'h1 << s, '0);
                                chk("R8 ack drops irq", {31'b0, irq}, 32'h0);
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule